// File: doc/BRIEF.md
# Low-Memory Register and Byte UART Address Decoder

This block sits on a 32-bit request bus and steers each access to one of three places. The first four words of the address space hold fixed, read-only registers. Two of them are constants. The other two mirror the program counter and status word of the running thread, which arrive on side inputs. A small polled byte port sits in the general I/O region. Every address at or above 512 MB goes to a RAM port. Any other I/O address, including the per-CPU windows below 128 MB, reads as zero, and writes to it are dropped.

The byte port has two channels. The transmit side holds one byte and offers it to an external serial model with a valid/accept handshake. The receive side captures one byte from the model with a valid/take handshake and keeps it until software reads it. Local targets answer in the same cycle as the request. RAM accesses finish when the RAM port reports ready. Serial bit timing is out of scope.

Top module: `lowmem_mmio_decoder`

## Requirements
- R1: A read of word address 0x0 returns 0x00000000. A read of 0x4 returns 0x80000000.
- R2: A read of 0x8 returns the current `pc_in` value. A read of 0xC returns the current `psw_in` value. Both reads are combinational.
- R3: A write to any address from 0x0 to 0xC has no effect: later reads return the values of R1/R2, no RAM request is raised, and the transmit channel does not change.
- R4: A write to 0x08000000 while no byte is pending raises `tx_valid` from the next cycle, with `tx_data` equal to `req_wdata[7:0]`. Both hold until the cycle in which `tx_accept` is high.
- R5: A read of 0x08000004 returns 1 in bit 0 (other bits zero) when no transmit byte is pending, and 0 otherwise. A transmit write made while a byte is pending is dropped, even if `tx_accept` is high in that same cycle.
- R6: When the receive buffer is empty, `rx_take` equals `rx_valid`, and the byte is captured at that edge. A read of 0x0800000C returns 1 in bit 0 while a captured byte is waiting. While the buffer is full, `rx_take` stays low.
- R7: A read of 0x08000008 returns the last captured byte, zero-extended to 32 bits. If a byte was waiting, the read empties the buffer from the next cycle.
- R8: Any access at or above 0x20000000 is forwarded unchanged to the RAM port: `ram_req` = `req_valid`, and address, write enable and write data pass through. `rsp_rdata` = `ram_rdata` and `rsp_ready` = `ram_ready`.
- R9: Below 0x20000000, reads of the transmit buffer and of every unmapped address return zero, and writes to them are ignored. Every non-RAM access has `rsp_ready` high in the same cycle and `ram_req` low.
- R10: After a synchronous reset, no transmit byte is pending, the receive buffer is empty, and it holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address (word aligned) |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data |
| rsp_ready | output | 1 | Access completes this cycle |
| pc_in | input | 32 | Program counter of the running thread |
| psw_in | input | 32 | Status word of the running thread |
| ram_req | output | 1 | RAM access request |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 32 | RAM address |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data |
| ram_ready | input | 1 | RAM access completes |
| tx_valid | output | 1 | Transmit byte offered |
| tx_data | output | 8 | Transmit byte |
| tx_accept | input | 1 | Serial model takes the transmit byte |
| rx_valid | input | 1 | Serial model offers a received byte |
| rx_data | input | 8 | Received byte |
| rx_take | output | 1 | Received byte captured this cycle |

## Verification
The assertions assume that the serial model keeps its handshakes well formed. `tx_accept` only counts while `tx_valid` is high, and a received byte may be offered again after being refused, so a blocked `rx_valid` has no side effects. They also assume that word addresses arrive aligned. Both the directed sequences and the randomized loop drive only aligned addresses, taken from a list that covers every mapped word, RAM, holes and per-CPU windows. The bench raises `tx_accept` and `rx_valid` freely, because the block must ignore them when they are irrelevant.

// File: rtl/lowmap_pkg.sv
package lowmap_pkg;

    localparam int WORD_W = 32;
    localparam int SEL_W  = 2;

    typedef enum logic [1:0] {
        TGT_FIXED = 2'd0,
        TGT_BYTE  = 2'd1,
        TGT_HOLE  = 2'd2,
        TGT_MEM   = 2'd3
    } target_e;

    // word offsets inside the byte-port window (address bits 3:2)
    localparam logic [SEL_W-1:0] PORT_TX_BUF  = 2'd0;
    localparam logic [SEL_W-1:0] PORT_TX_STAT = 2'd1;
    localparam logic [SEL_W-1:0] PORT_RX_BUF  = 2'd2;
    localparam logic [SEL_W-1:0] PORT_RX_STAT = 2'd3;

    typedef struct packed {
        logic              valid;
        logic              we;
        logic [SEL_W-1:0]  sel;
        logic [WORD_W-1:0] wdata;
    } local_acc_t;

    function automatic target_e classify(
        input logic [WORD_W-1:0] addr,
        input logic [WORD_W-1:0] mem_base,
        input logic [WORD_W-1:0] port_base
    );
        if (addr < WORD_W'(16))
            return TGT_FIXED;
        else if (addr[WORD_W-1:4] == port_base[WORD_W-1:4])
            return TGT_BYTE;
        else if (addr >= mem_base)
            return TGT_MEM;
        else
            return TGT_HOLE;
    endfunction

endpackage

// File: rtl/fixed_reg_bank.sv
module fixed_reg_bank
    import lowmap_pkg::*;
#(
    parameter logic [WORD_W-1:0] NEG_CONST = 32'h8000_0000
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [WORD_W-1:0] pc_in,
    input  logic [WORD_W-1:0] psw_in,
    output logic [WORD_W-1:0] rdata
);

    always_comb begin
        unique case (sel)
            2'd0:    rdata = '0;
            2'd1:    rdata = NEG_CONST;
            2'd2:    rdata = pc_in;
            default: rdata = psw_in;
        endcase
    end

endmodule

// File: rtl/byte_port.sv
module byte_port
    import lowmap_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  local_acc_t        acc,
    output logic [WORD_W-1:0] rdata,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_accept,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_take
);

    localparam int PAD_W = WORD_W - BYTE_W;

    logic              tx_busy;
    logic [BYTE_W-1:0] tx_hold;
    logic              rx_full;
    logic [BYTE_W-1:0] rx_hold;
    logic              wr_tx;
    logic              rd_rx;

    assign wr_tx = acc.valid &&  acc.we && (acc.sel == PORT_TX_BUF);
    assign rd_rx = acc.valid && !acc.we && (acc.sel == PORT_RX_BUF);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_busy <= 1'b0;
            tx_hold <= '0;
        end else if (tx_busy) begin
            if (tx_accept) tx_busy <= 1'b0;
        end else if (wr_tx) begin
            tx_busy <= 1'b1;
            tx_hold <= acc.wdata[BYTE_W-1:0];
        end
    end

    assign rx_take = rx_valid && !rx_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_full <= 1'b0;
            rx_hold <= '0;
        end else if (rx_full) begin
            if (rd_rx) rx_full <= 1'b0;
        end else if (rx_valid) begin
            rx_full <= 1'b1;
            rx_hold <= rx_data;
        end
    end

    assign tx_valid = tx_busy;
    assign tx_data  = tx_hold;

    always_comb begin
        unique case (acc.sel)
            PORT_TX_STAT: rdata = {{(WORD_W-1){1'b0}}, !tx_busy};
            PORT_RX_BUF:  rdata = {{PAD_W{1'b0}}, rx_hold};
            PORT_RX_STAT: rdata = {{(WORD_W-1){1'b0}}, rx_full};
            default:      rdata = '0;
        endcase
    end

    // R4: an offered byte stays put until the model accepts it
    assert_tx_hold_R4: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_accept |=> tx_valid && $stable(tx_data));

    // R5: a write during a pending byte cannot replace it
    assert_tx_drop_R5: assert property (@(posedge clk) disable iff (rst)
        tx_valid && wr_tx |=> $stable(tx_data));

    // R6: a capture leaves the buffer full, and a full buffer refuses
    assert_rx_fill_R6: assert property (@(posedge clk) disable iff (rst)
        rx_take |=> rx_full && !rx_take);

    // R7: reading a waiting byte empties the buffer
    assert_rx_drain_R7: assert property (@(posedge clk) disable iff (rst)
        rd_rx && rx_full |=> !rx_full);

endmodule

// File: rtl/lowmem_mmio_decoder.sv
module lowmem_mmio_decoder
    import lowmap_pkg::*;
#(
    parameter logic [31:0] MEM_BASE  = 32'h2000_0000,
    parameter logic [31:0] PORT_BASE = 32'h0800_0000,
    parameter logic [31:0] NEG_CONST = 32'h8000_0000,
    parameter int          BYTE_W    = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_we,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic [31:0] rsp_rdata,
    output logic        rsp_ready,
    input  logic [31:0] pc_in,
    input  logic [31:0] psw_in,
    output logic        ram_req,
    output logic        ram_we,
    output logic [31:0] ram_addr,
    output logic [31:0] ram_wdata,
    input  logic [31:0] ram_rdata,
    input  logic        ram_ready,
    output logic        tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic        tx_accept,
    input  logic        rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic        rx_take
);

    target_e           tgt;
    local_acc_t        port_acc;
    logic [WORD_W-1:0] fixed_rd;
    logic [WORD_W-1:0] port_rd;

    assign tgt = classify(req_addr, MEM_BASE, PORT_BASE);

    assign port_acc.valid = req_valid && (tgt == TGT_BYTE);
    assign port_acc.we    = req_we;
    assign port_acc.sel   = req_addr[3:2];
    assign port_acc.wdata = req_wdata;

    fixed_reg_bank #(.NEG_CONST(NEG_CONST)) u_fixed (
        .sel    (req_addr[3:2]),
        .pc_in  (pc_in),
        .psw_in (psw_in),
        .rdata  (fixed_rd)
    );

    byte_port #(.BYTE_W(BYTE_W)) u_port (
        .clk       (clk),
        .rst       (rst),
        .acc       (port_acc),
        .rdata     (port_rd),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_accept (tx_accept),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_take   (rx_take)
    );

    assign ram_req   = req_valid && (tgt == TGT_MEM);
    assign ram_we    = req_we;
    assign ram_addr  = req_addr;
    assign ram_wdata = req_wdata;

    always_comb begin
        unique case (tgt)
            TGT_FIXED: rsp_rdata = fixed_rd;
            TGT_BYTE:  rsp_rdata = port_rd;
            TGT_MEM:   rsp_rdata = ram_rdata;
            default:   rsp_rdata = '0;
        endcase
    end

    assign rsp_ready = req_valid && ((tgt == TGT_MEM) ? ram_ready : 1'b1);

    // R3: writes to the fixed words never reach memory and finish at once
    assert_fixed_local_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_we && (req_addr < 32'h10) |-> !ram_req && rsp_ready);

    // R8: a RAM request only ever carries a RAM address
    assert_mem_range_R8: assert property (@(posedge clk) disable iff (rst)
        ram_req |-> ram_addr >= MEM_BASE);

    // R9: holes answer locally with zero
    assert_hole_zero_R9: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_we && (tgt == TGT_HOLE) |-> rsp_ready && (rsp_rdata == 32'h0) && !ram_req);

endmodule

// File: tb/lowmem_mmio_decoder_test.sv
`timescale 1ns/1ps
module lowmem_mmio_decoder_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_we;
    logic [31:0] req_addr, req_wdata;
    logic [31:0] rsp_rdata;
    logic        rsp_ready;
    logic [31:0] pc_in, psw_in;
    logic        ram_req, ram_we;
    logic [31:0] ram_addr, ram_wdata, ram_rdata;
    logic        ram_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_accept;
    logic        rx_valid;
    logic [7:0]  rx_data;
    logic        rx_take;

    always #5 clk = ~clk;

    lowmem_mmio_decoder uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_ready(rsp_ready),
        .pc_in(pc_in), .psw_in(psw_in),
        .ram_req(ram_req), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata), .ram_ready(ram_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_accept(tx_accept),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_take(rx_take)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    // behavioural reference state
    bit       m_txp;
    bit [7:0] m_txb;
    bit       m_rxf;
    bit [7:0] m_rxb;

    localparam logic [31:0] A_TXB = 32'h0800_0000;
    localparam logic [31:0] A_TXS = 32'h0800_0004;
    localparam logic [31:0] A_RXB = 32'h0800_0008;
    localparam logic [31:0] A_RXS = 32'h0800_000C;
    localparam logic [31:0] A_RAM = 32'h2000_0000;

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h (cycle %0d)", tag, what, got, exp, cyc);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [31:0] a);
        if (a >= A_RAM) return ram_rdata;
        case (a)
            32'h0:  return 32'h0;
            32'h4:  return 32'h8000_0000;
            32'h8:  return pc_in;
            32'hC:  return psw_in;
            A_TXS:  return {31'h0, !m_txp};
            A_RXB:  return {24'h0, m_rxb};
            A_RXS:  return {31'h0, m_rxf};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string read_tag(input logic [31:0] a);
        if (a >= A_RAM) return "R8";
        if (a < 32'h8)  return "R1";
        if (a < 32'h10) return "R2";
        if (a == A_TXS) return "R5";
        if (a == A_RXB) return "R7";
        if (a == A_RXS) return "R6";
        return "R9";
    endfunction

    // compare all outputs, then advance one clock and update the model
    task automatic cycle();
        bit is_ram;
        string rtag;
        #1;
        is_ram = req_valid && (req_addr >= A_RAM);
        rtag = is_ram ? "R8" : (req_addr < 32'h10 ? "R3" : "R9");
        chk("R4", "tx_valid", {31'h0, tx_valid}, {31'h0, m_txp});
        if (m_txp) chk("R4", "tx_data", {24'h0, tx_data}, {24'h0, m_txb});
        chk("R6", "rx_take", {31'h0, rx_take}, {31'h0, rx_valid && !m_rxf});
        chk(rtag, "ram_req", {31'h0, ram_req}, {31'h0, is_ram});
        chk(rtag, "rsp_ready", {31'h0, rsp_ready},
            {31'h0, req_valid && (is_ram ? ram_ready : 1'b1)});
        if (is_ram) begin
            chk("R8", "ram_addr", ram_addr, req_addr);
            chk("R8", "ram_we", {31'h0, ram_we}, {31'h0, req_we});
            chk("R8", "ram_wdata", ram_wdata, req_wdata);
        end
        if (req_valid && !req_we)
            chk(read_tag(req_addr), "rsp_rdata", rsp_rdata, exp_read(req_addr));
        @(posedge clk);
        if (rst) begin
            m_txp = 0; m_txb = 0; m_rxf = 0; m_rxb = 0;
        end else begin
            if (m_txp) begin
                if (tx_accept) m_txp = 0;
            end else if (req_valid && req_we && req_addr == A_TXB) begin
                m_txp = 1; m_txb = req_wdata[7:0];
            end
            if (m_rxf) begin
                if (req_valid && !req_we && req_addr == A_RXB) m_rxf = 0;
            end else if (rx_valid) begin
                m_rxf = 1; m_rxb = rx_data;
            end
        end
        @(negedge clk);
    endtask

    task automatic acc(input logic v, input logic we, input logic [31:0] a, input logic [31:0] d);
        req_valid = v; req_we = we; req_addr = a; req_wdata = d;
        cycle();
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_cmp++; n_bad++;
                $display("FAIL watchdog: got %0d cycles expected completion", cyc);
                report();
            end
        end
    end

    initial begin
        logic [31:0] pick [12];
        rst = 1; req_valid = 0; req_we = 0; req_addr = 0; req_wdata = 0;
        pc_in = 32'h0000_0204; psw_in = 32'h2; ram_rdata = 32'hDEAD_BEEF; ram_ready = 1;
        tx_accept = 0; rx_valid = 0; rx_data = 8'h00;
        m_txp = 0; m_txb = 0; m_rxf = 0; m_rxb = 0;
        @(negedge clk);
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R10: reset state seen at the ports
        req_valid = 1; req_we = 0; req_addr = A_TXS;
        #1;
        chk("R10", "tx status after reset", rsp_rdata, 32'h1);
        chk("R10", "tx_valid after reset", {31'h0, tx_valid}, 32'h0);
        req_addr = A_RXS;
        #1;
        chk("R10", "rx status after reset", rsp_rdata, 32'h0);
        req_addr = A_RXB;
        #1;
        chk("R10", "rx buffer after reset", rsp_rdata, 32'h0);
        #1;
        req_valid = 0;

        // R1 / R2: fixed words
        acc(1, 0, 32'h0, 0);
        acc(1, 0, 32'h4, 0);
        acc(1, 0, 32'h8, 0);
        acc(1, 0, 32'hC, 0);
        pc_in = 32'hFFFF_FFFC; psw_in = 32'h1;
        acc(1, 0, 32'h8, 0);
        acc(1, 0, 32'hC, 0);

        // R3: writes to fixed words are dropped
        acc(1, 1, 32'h0, 32'h1234_5678);
        acc(1, 1, 32'h4, 32'h0);
        acc(1, 1, 32'h8, 32'hAAAA_AAAA);
        acc(1, 1, 32'hC, 32'h5555_5555);
        acc(1, 0, 32'h0, 0);
        acc(1, 0, 32'h4, 0);
        chk("R3", "tx_valid after fixed writes", {31'h0, tx_valid}, 32'h0);

        // R4 / R5: transmit, held until accepted, second write dropped
        acc(1, 1, A_TXB, 32'h0000_01A5);
        acc(1, 0, A_TXS, 0);
        acc(1, 1, A_TXB, 32'h0000_0077);
        acc(0, 0, 0, 0);
        tx_accept = 1;
        acc(1, 1, A_TXB, 32'h0000_0033);   // same-cycle accept: write dropped
        tx_accept = 0;
        acc(1, 0, A_TXS, 0);
        acc(1, 1, A_TXB, 32'h0000_00C3);
        tx_accept = 1;
        acc(0, 0, 0, 0);
        tx_accept = 0;
        acc(1, 0, A_TXS, 0);
        acc(1, 0, A_TXB, 0);

        // R6 / R7: receive, refusal while full, drain
        rx_valid = 1; rx_data = 8'h3C;
        acc(0, 0, 0, 0);
        rx_data = 8'hE1;
        acc(1, 0, A_RXS, 0);
        acc(1, 0, A_RXB, 0);
        acc(1, 0, A_RXS, 0);
        rx_valid = 0;
        acc(1, 0, A_RXB, 0);
        acc(1, 0, A_RXS, 0);
        acc(1, 0, A_RXB, 0);

        // R8: RAM pass-through with stalls
        ram_ready = 0; ram_rdata = 32'h0BAD_F00D;
        acc(1, 0, A_RAM, 0);
        ram_ready = 1;
        acc(1, 0, A_RAM, 0);
        acc(1, 1, 32'hFFFF_FFFC, 32'hCAFE_0001);
        acc(0, 1, 32'h3000_0000, 32'h1);

        // R9: holes and per-CPU windows
        acc(1, 1, 32'h0000_0100, 32'hFFFF_FFFF);
        acc(1, 0, 32'h0000_0100, 0);
        acc(1, 0, 32'h0400_0000, 0);
        acc(1, 0, 32'h0800_0010, 0);
        acc(1, 1, 32'h1FFF_FFFC, 32'h1);
        acc(1, 0, 32'h1FFF_FFFC, 0);

        // mixed traffic
        pick = '{32'h0, 32'h4, 32'h8, 32'hC, A_TXB, A_TXS, A_RXB, A_RXS,
                 32'h0700_0000, 32'h1000_0000, A_RAM, 32'h8000_0040};
        for (int i = 0; i < 600; i++) begin
            pc_in     = $urandom;
            psw_in    = {30'h0, 2'($urandom)};
            ram_rdata = $urandom;
            ram_ready = 1'($urandom);
            tx_accept = 1'($urandom);
            rx_valid  = ($urandom_range(0, 3) == 0);
            rx_data   = 8'($urandom);
            acc(1'($urandom_range(0, 7) != 0), 1'($urandom), pick[$urandom_range(0, 11)], $urandom);
        end

        report();
    end

endmodule